// File: doc/BRIEF.md
# Cascadable Presettable Counter Stage

This block is one stage of a synchronous up counter: a small register that loads a parallel value, counts by one, or holds, all on the rising clock edge. Two parameters fix its character at build time. One picks the count range: ten states (0 to 9) or the full range of the register (0 to 15 at the default width of four). The other picks how the active-low clear acts: straight away without waiting for the clock, or only at the next rising edge.

Counting needs both enables high. The enables differ in one respect. The carry output is combinational and depends only on `en_t` and on the stage being at its last value. `en_p` has no effect on it. To build a wider counter, the carry of one stage drives both enables of the next stage. Every stage shares one clock and no outside gates are needed. A stage in the ten-state build that is loaded with 10 to 15 keeps counting up and returns to 0 after 15. Its carry stays low on those values.

Top module: `casc_counter4`

## Requirements
- R1: With ASYNC_CLR=1, a low `clr_n` forces `q` to 0 at once, without a clock edge, and keeps it at 0 while `clr_n` stays low.
- R2: With ASYNC_CLR=0, a low `clr_n` leaves `q` unchanged until the next rising edge and sets `q` to 0 at that edge.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`.
- R4: Precedence at a rising edge is clear, then load, then count. A low `clr_n` overrides a low `load_n`, and a low `load_n` overrides the enables.
- R5: When `clr_n` and `load_n` are high and both `en_p` and `en_t` are high at a rising edge, `q` steps up by one.
- R6: When `clr_n` and `load_n` are high and either `en_p` or `en_t` is low at a rising edge, `q` holds its value.
- R7: With DECADE=1, a count step from 9 gives 0.
- R8: With DECADE=0, a count step from 15 gives 0.
- R9: `carry` is 1 exactly when `en_t` is 1 and `q` holds the last value (9 with DECADE=1, 15 with DECADE=0). `en_p` does not affect `carry`.
- R10: With DECADE=1, a stage holding 10 to 15 counts up by one per step and goes from 15 to 0. `carry` stays 0 on those values.
- R11: Two stages, where the low stage's `carry` drives both enables of the high stage, count as one two-digit decimal counter (DECADE=1) or as one 8-bit binary counter (DECADE=0). The high stage is the upper digit or nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All loads and count steps happen on its rising edge |
| clr_n | input | 1 | Active-low clear. It acts at once or at the edge, as ASYNC_CLR selects |
| load_n | input | 1 | Active-low parallel load, synchronous |
| din | input | WIDTH | Parallel preset value |
| en_p | input | 1 | Count enable. It has no effect on the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | WIDTH | Counter state |
| carry | output | 1 | Last-value indicator, gated by en_t |

## Verification
The bench builds two chained pairs, each with WIDTH=4. One pair has DECADE=1 and ASYNC_CLR=1. The other has DECADE=0 and ASYNC_CLR=0. Driving a common clear mid-cycle therefore shows both clear timings side by side. The decimal pair covers the 9-to-0 wrap, the over-range values 10 to 15 and the two-digit carry chain. The binary pair covers the 15-to-0 wrap, the full 8-bit carry chain, and a high stage that steps on every edge while its low stage is held at 15 with `en_t` high.

// File: rtl/cnt4_pkg.sv
package cnt4_pkg;

  // Action chosen for the next rising edge, in precedence order
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

endpackage

// File: rtl/cnt4_decide.sv
module cnt4_decide
  import cnt4_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic en_p,
  input  logic en_t,
  output act_e act
);

  // Clear beats load, load beats count (R4)
  always_comb begin
    if (!clr_n)
      act = ACT_CLEAR;
    else if (!load_n)
      act = ACT_LOAD;
    else if (en_p && en_t)
      act = ACT_COUNT;
    else
      act = ACT_HOLD;
  end

endmodule

// File: rtl/cnt4_step.sv
module cnt4_step #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_inc,
  output logic             at_last
);

  localparam logic [WIDTH-1:0] LAST = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  // Values above LAST (ten-state build only) roll over naturally at the
  // top of the register (R10)
  always_comb begin
    at_last = (q == LAST);
    if (at_last)
      q_inc = '0;
    else
      q_inc = q + 1'b1;
  end

endmodule

// File: rtl/cnt4_state.sv
module cnt4_state
  import cnt4_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  act_e             act,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] q_inc,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  always_comb begin
    q_en  = (act != ACT_HOLD);
    q_nxt = q;
    case (act)
      ACT_CLEAR: q_nxt = '0;
      ACT_LOAD:  q_nxt = din;
      ACT_COUNT: q_nxt = q_inc;
      default:   q_nxt = q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
          q <= '0;
        else if (q_en)
          q <= q_nxt;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (q_en)
          q <= q_nxt;
      end
    end
  endgenerate

endmodule

// File: rtl/casc_counter4.sv
module casc_counter4
  import cnt4_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             carry
);

  act_e             act;
  logic [WIDTH-1:0] q_inc;
  logic             at_last;

  cnt4_decide u_decide (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .act    (act)
  );

  cnt4_step #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
  ) u_step (
    .q       (q),
    .q_inc   (q_inc),
    .at_last (at_last)
  );

  cnt4_state #(
    .WIDTH     (WIDTH),
    .ASYNC_CLR (ASYNC_CLR)
  ) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .act   (act),
    .din   (din),
    .q_inc (q_inc),
    .q     (q)
  );

  // The carry does not wait for a register stage, so a chain of stages
  // sees it within the same clock period
  assign carry = en_t & at_last;

endmodule

// File: rtl/casc_counter4_chk.sv
module casc_counter4_chk #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] q,
  input logic             carry
);

  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};

  // clr_n is the reset of this block. The clear checks therefore use no
  // disable clause.
  generate
    if (ASYNC_CLR) begin : g_async
      p_async_clear_r1: assert property (@(posedge clk)
        !clr_n |-> (q == '0));
    end else begin : g_sync
      p_sync_clear_r2: assert property (@(posedge clk)
        !clr_n |=> (q == '0));
    end
  endgenerate

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> (q == $past(din)));

  p_count_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q != TERM && q != TOP)
      |=> (q == WIDTH'($past(q) + 1'b1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  p_carry_t_r9: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> en_t);

  p_carry_term_r9: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> (q == TERM));

  generate
    if (DECADE) begin : g_dec
      p_wrap_nine_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q == WIDTH'(9)) |=> (q == '0));
      p_over_wrap_r10: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q == TOP) |=> (q == '0));
    end else begin : g_bin
      p_wrap_top_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q == TOP) |=> (q == '0));
    end
  endgenerate

endmodule

bind casc_counter4 casc_counter4_chk #(
  .WIDTH     (WIDTH),
  .DECADE    (DECADE),
  .ASYNC_CLR (ASYNC_CLR)
) i_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .din    (din),
  .en_p   (en_p),
  .en_t   (en_t),
  .q      (q),
  .carry  (carry)
);

// File: tb/test_casc_counter4.sv
`timescale 1ns/1ps
module test_casc_counter4;

  logic       clk = 1'b0;
  logic       clr_n, load_n, en_p, en_t;
  logic [3:0] d_dlo, d_dhi, d_blo, d_bhi;
  logic [3:0] dlo_q, dhi_q, blo_q, bhi_q;
  logic       dlo_c, dhi_c, blo_c, bhi_c;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // Decimal pair, immediate clear
  casc_counter4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) i_casc_counter4 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_dlo),
    .en_p(en_p), .en_t(en_t), .q(dlo_q), .carry(dlo_c));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) i_dec_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_dhi),
    .en_p(dlo_c), .en_t(dlo_c), .q(dhi_q), .carry(dhi_c));
  // Binary pair, clear on the edge
  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) i_bin_lo (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_blo),
    .en_p(en_p), .en_t(en_t), .q(blo_q), .carry(blo_c));
  casc_counter4 #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) i_bin_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(d_bhi),
    .en_p(blo_c), .en_t(blo_c), .q(bhi_q), .carry(bhi_c));

  typedef struct packed {
    logic [3:0] dlo, dhi, blo, bhi;
    logic       dc_lo, dc_hi, bc_lo, bc_hi;
  } exp_t;

  exp_t  sbq[$];
  string tagq[$];
  logic [3:0] m_dlo = '0, m_dhi = '0, m_blo = '0, m_bhi = '0;

  function automatic logic [3:0] m_next(input logic [3:0] q, input bit dec,
      input bit clr, input bit ld, input logic [3:0] d, input bit p, input bit t);
    if (!clr)        return 4'd0;
    else if (!ld)    return d;
    else if (p && t) return (dec && q == 4'd9) ? 4'd0 : q + 4'd1;
    else             return q;
  endfunction

  function automatic bit m_tc(input logic [3:0] q, input bit dec, input bit t);
    return t && (q == (dec ? 4'd9 : 4'd15));
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs for one edge and push the expected result
  task automatic step(input string tag, input bit clr, input bit ld, input bit p,
      input bit t, input logic [3:0] a, input logic [3:0] b,
      input logic [3:0] c, input logic [3:0] d);
    exp_t e;
    bit cd, cb;
    @(negedge clk);
    clr_n = clr; load_n = ld; en_p = p; en_t = t;
    d_dlo = a; d_dhi = b; d_blo = c; d_bhi = d;
    cd = m_tc(m_dlo, 1'b1, t);
    cb = m_tc(m_blo, 1'b0, t);
    m_dhi = m_next(m_dhi, 1'b1, clr, ld, b, cd, cd);
    m_dlo = m_next(m_dlo, 1'b1, clr, ld, a, p, t);
    m_bhi = m_next(m_bhi, 1'b0, clr, ld, d, cb, cb);
    m_blo = m_next(m_blo, 1'b0, clr, ld, c, p, t);
    e.dlo = m_dlo; e.dhi = m_dhi; e.blo = m_blo; e.bhi = m_bhi;
    e.dc_lo = m_tc(m_dlo, 1'b1, t);
    e.dc_hi = m_tc(m_dhi, 1'b1, e.dc_lo);
    e.bc_lo = m_tc(m_blo, 1'b0, t);
    e.bc_hi = m_tc(m_bhi, 1'b0, e.bc_lo);
    sbq.push_back(e);
    tagq.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t  e;
        string tg;
        e  = sbq.pop_front();
        tg = tagq.pop_front();
        chk(tg, "dec lo q", dlo_q, e.dlo);
        chk(tg, "dec hi q", dhi_q, e.dhi);
        chk(tg, "bin lo q", blo_q, e.blo);
        chk(tg, "bin hi q", bhi_q, e.bhi);
        chk(tg, "dec lo carry", dlo_c, e.dc_lo);
        chk(tg, "dec hi carry", dhi_c, e.dc_hi);
        chk(tg, "bin lo carry", blo_c, e.bc_lo);
        chk(tg, "bin hi carry", bhi_c, e.bc_hi);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    d_dlo = '0; d_dhi = '0; d_blo = '0; d_bhi = '0;

    // Reset state: R1 and R2 both give zero
    repeat (2) step("R1/R2", 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0);
    // Preset: decimal 37, binary 0xFD
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 4'd3, 4'hD, 4'hF);
    // Chained counting through 9->0 and 0xFF->0x00
    repeat (40) step("R5/R7/R8/R11", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0);
    // Low stages at their last value, then en_p low: hold, carry still high
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 4'd4, 4'hF, 4'h2);
    repeat (3) step("R6/R9", 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0);
    // en_t low: hold, carry low
    repeat (2) step("R6/R9", 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0);
    // Load beats count, clear beats load
    step("R4", 1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 4'd5, 4'd3, 4'd6);
    step("R4", 1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 4'd8, 4'd8, 4'd8);
    // Over-range decimal values
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 4'd12, 4'd1, 4'd0, 4'd0);
    repeat (6) step("R10", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0);
    // Non-zero state ahead of the clear timing check
    step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 4'd6, 4'd7, 4'd8);

    while (sbq.size() != 0) @(posedge clk);
    @(posedge clk);
    #3 clr_n = 1'b0;
    #2;
    chk("R1", "dec lo q mid-cycle", dlo_q, 0);
    chk("R1", "dec hi q mid-cycle", dhi_q, 0);
    chk("R2", "bin lo q mid-cycle", blo_q, int'(m_blo));
    chk("R2", "bin hi q mid-cycle", bhi_q, int'(m_bhi));
    @(posedge clk);
    #2;
    chk("R2", "bin lo q after edge", blo_q, 0);
    chk("R2", "bin hi q after edge", bhi_q, 0);
    chk("R1", "dec lo q held", dlo_q, 0);
    m_dlo = '0; m_dhi = '0; m_blo = '0; m_bhi = '0;

    repeat (3) step("R5", 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0, 4'd0, 4'd0);
    while (sbq.size() != 0) @(posedge clk);
    @(posedge clk);
    #5;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule